// File: doc/BRIEF.md
# Flexible Refresh Scheduler

This block decides, at each scheduled evaluation point, whether a DRAM rank refreshes now, delays the refresh while traffic is waiting, or refreshes early while the rank is idle. It keeps a free-running cycle clock and one planned evaluation time. Each evaluation reprograms that time by zero cycles, by one refresh duration, or by one effective interval. The effective interval is the base refresh period divided by the refresh-mode multiplier. Both the delay limit and the early-refresh limit are their configured values scaled by the same multiplier.

Delayed refreshes are paid back later in a back-to-back burst. Early refreshes are paid back by skipping the same number of later intervals. After either sequence the schedule snaps back onto the interval grid. A realign input also snaps the plan onto the grid, measured from the current time. The block covers one rank context. Command generation and data-path timing belong to other blocks.

The state code on `fsm_state` is: 0 normal, 1 delaying, 2 early, 3 burst, 4 align, 5 skip. All examples below use the defaults: interval 32 cycles, delay limit 4, early limit 2, refresh duration 4.

Top module: `flex_refresh_sched`

## Requirements
- R1: After reset, `eval_stb`, `ref_issue`, `next_delay`, `fsm_state` (code 0) and `err` are all zero. The first evaluation happens at cycle time equal to one interval (32).
- R2: In state 0, when neither delaying nor early refresh applies, an evaluation refreshes, stays in state 0, and programs a delay of one interval. `ref_issue` is only ever high together with `eval_stb`.
- R3: In state 0, with delaying enabled, a request pending and the delay count below its limit, the evaluation does not refresh, moves to state 1 and programs delay 0. No evaluation that lands in state 1 refreshes.
- R4: In state 1, each evaluation increments the delay count. While the count does not exceed the limit and a request is pending, the block stays in state 1 with a one-interval delay. Once the count exceeds the limit, the block moves to state 3 with delay 0 and issues that many refreshes on consecutive cycles.
- R5: In state 1 with the force-maximum option off, an evaluation that sees no pending request moves to state 3 at once and bursts out only the refreshes owed so far.
- R6: In state 0, with early refresh enabled, no request pending and the early count below its limit, the block refreshes and enters state 2 with a delay of one refresh duration. While early refresh is still allowed it keeps refreshing, incrementing the count, so limit+1 refreshes are spaced one refresh duration apart.
- R7: In state 2, an evaluation where early refresh is no longer allowed (limit reached or request pending) issues no refresh and moves to state 4 with delay 0.
- R8: State 4 plans the next evaluation at the planned time rounded down to the interval grid, plus one interval, without refreshing. The next state is 5 if the state before state 4 was 2, and 0 otherwise.
- R9: In state 5, each evaluation with a nonzero early count decrements it and waits one interval without refreshing. With a zero count the block returns to state 0 with delay 0.
- R10: A `realign` pulse replans the next evaluation to the current time rounded down to the grid plus one interval. The state is kept, and any evaluation due in that same cycle is suppressed.
- R11: `fsm_state` only holds codes 0 to 5. An illegal code is forced back to 0 with both counts cleared, and the sticky `err` flag is set. `err` stays low in legal operation.
- R12: Every decision with delay 0 is followed by another evaluation on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_req | input | 1 | Requests are waiting for this rank |
| postpone_en | input | 1 | Allows refreshes to be delayed |
| pullin_en | input | 1 | Allows refreshes to be issued early |
| force_max_burst | input | 1 | Keep delaying to the limit even when idle |
| realign | input | 1 | Replan the next evaluation onto the interval grid |
| eval_stb | output | 1 | An evaluation took place on the previous edge |
| ref_issue | output | 1 | That evaluation issued a refresh |
| next_delay | output | TIME_W | Delay programmed by the last evaluation |
| fsm_state | output | 3 | State entered by the last evaluation |
| err | output | 1 | Sticky illegal-state flag |

## Verification
A realign pulse and a due evaluation can fall on the same edge. The realign must win: it replans from the current grid cell, and the evaluation that was due is dropped. The bench provokes this by leaving an early-refresh sequence planned 4 cycles ahead, then raising `realign` on exactly the edge where that evaluation is due. It then judges that no strobe appears for that edge. The next evaluation must arrive at the next grid point, still in state 2 and with a refresh, which shows the state and count were untouched.

// File: rtl/flex_refresh_sched.sv
module flex_refresh_sched #(
  parameter int TREFI_CYC    = 64,
  parameter int REF_MODE     = 2,
  parameter int POSTPONE_CFG = 2,
  parameter int PULLIN_CFG   = 1,
  parameter int REF_CYC      = 4,
  parameter int TIME_W       = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pend_req,
  input  logic              postpone_en,
  input  logic              pullin_en,
  input  logic              force_max_burst,
  input  logic              realign,
  output logic              eval_stb,
  output logic              ref_issue,
  output logic [TIME_W-1:0] next_delay,
  output logic [2:0]        fsm_state,
  output logic              err
);
  localparam int INTV   = TREFI_CYC / REF_MODE;
  localparam int MAX_PP = POSTPONE_CFG * REF_MODE;
  localparam int MAX_PI = PULLIN_CFG * REF_MODE;
  localparam int CNT_W  = $clog2(((MAX_PP > MAX_PI) ? MAX_PP : MAX_PI) + 2);
  localparam logic [TIME_W-1:0] INTV_T  = TIME_W'(INTV);
  localparam logic [TIME_W-1:0] DUR_T   = TIME_W'(REF_CYC);
  localparam logic [CNT_W-1:0]  MAXPP_C = CNT_W'(MAX_PP);
  localparam logic [CNT_W-1:0]  MAXPI_C = CNT_W'(MAX_PI);

  localparam logic [2:0] S_REF   = 3'd0;
  localparam logic [2:0] S_POST  = 3'd1;
  localparam logic [2:0] S_PULL  = 3'd2;
  localparam logic [2:0] S_BURST = 3'd3;
  localparam logic [2:0] S_ALIGN = 3'd4;
  localparam logic [2:0] S_SKIP  = 3'd5;

  logic [2:0]        st, prev_st, nst;
  logic [CNT_W-1:0]  pp_cnt, pi_cnt, pp_nx, pi_nx, pp_inc;
  logic [TIME_W-1:0] nw_base, nw_phase, pl_base, pl_off;
  logic [TIME_W-1:0] dly, diff, off_sum, base_nx, off_nx;
  logic              due, bad, do_ref, do_align, may_pp, may_pi;

  assign diff   = (nw_base + nw_phase) - (pl_base + pl_off);
  assign due    = ~diff[TIME_W-1] & ~realign;
  assign bad    = (st > S_SKIP);
  assign may_pp = postpone_en & pend_req & (pp_cnt < MAXPP_C);
  assign may_pi = pullin_en & ~pend_req & (pi_cnt < MAXPI_C);
  assign pp_inc = pp_cnt + 1'b1;
  assign fsm_state = st;

  always_comb begin
    nst      = st;
    pp_nx    = pp_cnt;
    pi_nx    = pi_cnt;
    do_ref   = 1'b0;
    do_align = 1'b0;
    dly      = '0;
    case (st)
      S_REF: begin
        if (may_pp) begin
          nst = S_POST;
        end else if (may_pi) begin
          do_ref = 1'b1;
          dly    = DUR_T;
          nst    = S_PULL;
        end else begin
          do_ref = 1'b1;
          dly    = INTV_T;
        end
      end
      S_PULL: begin
        if (may_pi) begin
          do_ref = 1'b1;
          pi_nx  = pi_cnt + 1'b1;
          dly    = DUR_T;
        end else begin
          nst = S_ALIGN;
        end
      end
      S_SKIP: begin
        if (pi_cnt == '0) begin
          nst = S_REF;
        end else begin
          pi_nx = pi_cnt - 1'b1;
          dly   = INTV_T;
        end
      end
      S_POST: begin
        pp_nx = pp_inc;
        if ((pp_inc > MAXPP_C) || (!pend_req && !force_max_burst)) begin
          nst = S_BURST;
        end else begin
          dly = INTV_T;
        end
      end
      S_BURST: begin
        do_ref = 1'b1;
        pp_nx  = pp_cnt - 1'b1;
        if (pp_nx == '0) nst = S_ALIGN;
      end
      S_ALIGN: begin
        do_align = 1'b1;
        dly      = INTV_T;
        nst      = (prev_st == S_PULL) ? S_SKIP : S_REF;
      end
      default: begin
        nst   = S_REF;
        pp_nx = '0;
        pi_nx = '0;
      end
    endcase
  end

  always_comb begin
    off_sum = pl_off + dly;
    base_nx = pl_base;
    off_nx  = pl_off;
    if (realign) begin
      base_nx = nw_base + INTV_T;
      off_nx  = '0;
    end else if (due) begin
      if (do_align) begin
        base_nx = pl_base + INTV_T;
        off_nx  = '0;
      end else if (off_sum >= INTV_T) begin
        base_nx = pl_base + INTV_T;
        off_nx  = off_sum - INTV_T;
      end else begin
        off_nx = off_sum;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nw_base  <= '0;
      nw_phase <= '0;
      pl_base  <= INTV_T;
      pl_off   <= '0;
    end else begin
      if (nw_phase == INTV_T - 1'b1) begin
        nw_phase <= '0;
        nw_base  <= nw_base + INTV_T;
      end else begin
        nw_phase <= nw_phase + 1'b1;
      end
      pl_base <= base_nx;
      pl_off  <= off_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_REF;
      prev_st    <= S_REF;
      pp_cnt     <= '0;
      pi_cnt     <= '0;
      eval_stb   <= 1'b0;
      ref_issue  <= 1'b0;
      next_delay <= '0;
      err        <= 1'b0;
    end else begin
      eval_stb  <= due & ~bad;
      ref_issue <= due & ~bad & do_ref;
      if (bad) begin
        st     <= S_REF;
        pp_cnt <= '0;
        pi_cnt <= '0;
        err    <= 1'b1;
      end else if (due) begin
        st         <= nst;
        prev_st    <= st;
        pp_cnt     <= pp_nx;
        pi_cnt     <= pi_nx;
        next_delay <= dly;
      end
    end
  end
endmodule

// File: rtl/flex_refresh_sched_chk.sv
module flex_refresh_sched_chk #(
  parameter int TIME_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              realign,
  input logic              eval_stb,
  input logic              ref_issue,
  input logic [TIME_W-1:0] next_delay,
  input logic [2:0]        fsm_state,
  input logic              err
);
  p_ref_on_eval_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ref_issue |-> eval_stb);

  p_post_no_ref_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_stb && fsm_state == 3'd1) |-> !ref_issue);

  p_skip_no_ref_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_stb && fsm_state == 3'd5) |-> !ref_issue);

  p_realign_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    realign |=> !eval_stb);

  p_legal_state_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fsm_state <= 3'd5);

  p_err_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !err);

  p_zero_delay_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_stb && next_delay == '0 && !realign) |=> eval_stb);
endmodule

bind flex_refresh_sched flex_refresh_sched_chk #(.TIME_W(TIME_W)) u_chk (.*);

// File: tb/tb_flex_refresh_sched.sv
module tb_flex_refresh_sched;
  localparam int TW = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pend_req = 1'b0, postpone_en = 1'b0, pullin_en = 1'b0;
  logic force_max_burst = 1'b0, realign = 1'b0;
  logic eval_stb, ref_issue, err;
  logic [TW-1:0] next_delay;
  logic [2:0] fsm_state;
  int cyc, n_chk, n_err;

  flex_refresh_sched dut (
    .clk(clk), .rst_n(rst_n), .pend_req(pend_req), .postpone_en(postpone_en),
    .pullin_en(pullin_en), .force_max_burst(force_max_burst), .realign(realign),
    .eval_stb(eval_stb), .ref_issue(ref_issue), .next_delay(next_delay),
    .fsm_state(fsm_state), .err(err)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pend_req = 1'b0; postpone_en = 1'b0; pullin_en = 1'b0;
    force_max_burst = 1'b0; realign = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_eval(output int t, output int r, output int s, output int d);
    t = -1; r = -1; s = -1; d = -1;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (eval_stb) begin
        t = cyc - 1; r = int'(ref_issue); s = int'(fsm_state); d = int'(next_delay);
        return;
      end
    end
  endtask

  task automatic expect_eval(string req, int et, int er, int es, int ed);
    int t, r, s, d;
    wait_eval(t, r, s, d);
    chk({req, " time"}, t, et);
    chk({req, " refresh"}, r, er);
    chk({req, " state"}, s, es);
    if (ed >= 0) chk({req, " delay"}, d, ed);
  endtask

  task automatic t_reset_normal();
    do_reset();
    @(negedge clk);
    chk("R1 eval", int'(eval_stb), 0);
    chk("R1 ref", int'(ref_issue), 0);
    chk("R1 state", int'(fsm_state), 0);
    chk("R1 delay", int'(next_delay), 0);
    chk("R1 err", int'(err), 0);
    pend_req = 1'b1;
    expect_eval("R1 first", 32, 1, 0, 32);
    expect_eval("R2 periodic", 64, 1, 0, 32);
    expect_eval("R2 periodic", 96, 1, 0, 32);
  endtask

  task automatic t_postpone_max();
    do_reset();
    postpone_en = 1'b1; pend_req = 1'b1; force_max_burst = 1'b1;
    expect_eval("R3 enter", 32, 0, 1, 0);
    expect_eval("R12 R4 hold", 33, 0, 1, 32);
    expect_eval("R4 hold", 64, 0, 1, 32);
    expect_eval("R4 hold", 96, 0, 1, 32);
    expect_eval("R4 hold", 128, 0, 1, 32);
    expect_eval("R4 to burst", 160, 0, 3, 0);
    for (int i = 0; i < 5; i++)
      expect_eval("R4 burst", 161 + i, 1, (i == 4) ? 4 : 3, 0);
    pend_req = 1'b0;
    expect_eval("R8 align", 166, 0, 0, 32);
    expect_eval("R8 grid", 192, 1, 0, 32);
    chk("R11 err", int'(err), 0);
  endtask

  task automatic t_postpone_idle();
    do_reset();
    postpone_en = 1'b1; pend_req = 1'b1;
    expect_eval("R3 enter", 32, 0, 1, 0);
    expect_eval("R4 hold", 33, 0, 1, 32);
    pend_req = 1'b0;
    expect_eval("R5 idle exit", 64, 0, 3, 0);
    expect_eval("R5 burst", 65, 1, 3, 0);
    expect_eval("R5 burst", 66, 1, 4, 0);
    expect_eval("R8 align", 67, 0, 0, 32);
    expect_eval("R8 grid", 96, 1, 0, 32);
  endtask

  task automatic t_pullin_full();
    do_reset();
    pullin_en = 1'b1;
    expect_eval("R6 first", 32, 1, 2, 4);
    expect_eval("R6 early", 36, 1, 2, 4);
    expect_eval("R6 early", 40, 1, 2, 4);
    expect_eval("R7 limit", 44, 0, 4, 0);
    expect_eval("R8 align skip", 45, 0, 5, 32);
    expect_eval("R9 skip", 64, 0, 5, 32);
    expect_eval("R9 skip", 96, 0, 5, 32);
    pullin_en = 1'b0;
    expect_eval("R9 back", 128, 0, 0, 0);
    expect_eval("R9 normal", 129, 1, 0, 32);
    expect_eval("R9 planned", 160, 1, 0, 32);
    chk("R11 err", int'(err), 0);
  endtask

  task automatic t_pullin_break();
    do_reset();
    pullin_en = 1'b1;
    expect_eval("R6 first", 32, 1, 2, 4);
    pend_req = 1'b1;
    expect_eval("R7 pending", 36, 0, 4, 0);
    expect_eval("R8 align skip", 37, 0, 5, 32);
    expect_eval("R9 zero", 64, 0, 0, 0);
    expect_eval("R9 normal", 65, 1, 0, 32);
    expect_eval("R2 normal", 96, 1, 0, 32);
  endtask

  task automatic t_realign_collide();
    int seen;
    do_reset();
    pullin_en = 1'b1;
    expect_eval("R6 first", 32, 1, 2, 4);
    seen = 0;
    while (cyc < 36) begin
      @(negedge clk);
      if (eval_stb) seen++;
    end
    realign = 1'b1;
    @(negedge clk);
    realign = 1'b0;
    chk("R10 suppressed", int'(eval_stb) + seen, 0);
    expect_eval("R10 grid", 64, 1, 2, 4);
    chk("R11 err", int'(err), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0; n_err = 0;
    t_reset_normal();
    t_postpone_max();
    t_postpone_idle();
    t_pullin_full();
    t_pullin_break();
    t_realign_collide();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule